// File: doc/BRIEF.md
# Privilege-Checked Register File

This block is the architectural register file of a small CPU core: sixteen 32-bit entries, two read ports that answer combinationally, and one write port that commits on the rising clock edge. Entries hold raw bit patterns. The core may treat them as Boolean vectors, signed two's-complement numbers or unsigned numbers, and the block never interprets them.

Entry 0 is a constant zero. Entries 1 to 12 are general purpose. The three top entries (13, 14, 15) hold system state: a pointer, the interrupt-descriptor-table base and a control word. The core sends its current privilege level with every write. An unprivileged write to one of the system entries is dropped, and the block raises a protection-fault strobe in the same cycle as the request. Reads are open to every privilege level. What the system entries mean, and what the core does after a fault, are handled outside this block.

Top module: `priv_regfile`

## Requirements
- R1: A synchronous active-high reset clears every entry to zero. On the cycle after reset is released, both read ports return zero for any index.
- R2: Index 0 always reads as zero. A write to index 0 has no effect and raises no fault, whatever the privilege level.
- R3: A write with `wr_en`=1 to an index from 1 to 12 stores `wr_data` at the next rising edge, for either value of `wr_priv`.
- R4: A write to index 13, 14 or 15 with `wr_priv`=1 (privileged) stores `wr_data` at the next rising edge.
- R5: A write to index 13, 14 or 15 with `wr_priv`=0 (unprivileged) leaves the target entry unchanged.
- R6: `gp_fault` is 1, combinationally in the cycle of the request, exactly when `wr_en`=1, `rst`=0, `wr_priv`=0 and `wr_idx` is 13, 14 or 15. It is 0 in every other cycle.
- R7: A read of an index that is being written in the same cycle returns the value held before the write. The new value is visible from the cycle after the edge.
- R8: Both read ports return the contents of any index, including 13 to 15, independently of each other and without regard to privilege.
- R9: All 32 bits of a written pattern are stored and returned unchanged, including all-ones and a set sign bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write target index |
| wr_data | input | 32 | Write value |
| wr_priv | input | 1 | 1 = core is privileged during this request |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A value (combinational) |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B value (combinational) |
| gp_fault | output | 1 | Protection fault strobe, same cycle as the request |

## Verification
Read data and the fault strobe follow the inputs of the same cycle, with zero cycles of latency. A write shows up on the read ports one edge later. The bench drives each cycle's inputs just after the falling edge and compares both read ports and the fault strobe a moment later, before the rising edge. It updates its behavioural model only at that rising edge. As a result, a same-cycle read is checked against the old value, and the new value is checked from the following cycle on.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  typedef enum logic [1:0] {
    SLOT_ZERO = 2'd0,
    SLOT_GP   = 2'd1,
    SLOT_SYS  = 2'd2
  } slot_kind_e;

  function automatic slot_kind_e slot_kind(input int idx, input int sys_first);
    if (idx == 0)
      return SLOT_ZERO;
    else if (idx >= sys_first)
      return SLOT_SYS;
    else
      return SLOT_GP;
  endfunction

endpackage

// File: rtl/priv_gate.sv
module priv_gate
  import regfile_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int SYS_FIRST = 13,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             rst,
  input  logic             req_en,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_priv,
  output logic             commit_en,
  output logic             fault
);

  slot_kind_e kind;

  always_comb begin
    kind      = slot_kind(int'(req_idx), SYS_FIRST);
    commit_en = 1'b0;
    fault     = 1'b0;
    if (req_en && !rst) begin
      unique case (kind)
        SLOT_ZERO: commit_en = 1'b0;
        SLOT_GP:   commit_en = 1'b1;
        SLOT_SYS: begin
          commit_en = req_priv;
          fault     = !req_priv;
        end
        default:   commit_en = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/reg_store.sv
module reg_store #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 16,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IDX_W-1:0]         widx,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_RD*IDX_W-1:0]  raddr,
  output logic [NUM_RD*DATA_W-1:0] rdata
);

  // entry 0 has no storage: it is the constant zero
  logic [DATA_W-1:0] mem [1:NUM_REGS-1];

  always_ff @(posedge clk) begin
    for (int i = 1; i < NUM_REGS; i++) begin
      if (rst)
        mem[i] <= '0;
      else if (we && widx == IDX_W'(i))
        mem[i] <= wdata;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [IDX_W-1:0]  a;
    logic [DATA_W-1:0] d;
    assign a = raddr[p*IDX_W +: IDX_W];
    always_comb begin
      d = '0;
      for (int i = 1; i < NUM_REGS; i++)
        if (a == IDX_W'(i)) d = mem[i];
    end
    assign rdata[p*DATA_W +: DATA_W] = d;
  end

endmodule

// File: rtl/priv_regfile.sv
module priv_regfile #(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 16,
  parameter int SYS_FIRST = 13,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_priv,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              gp_fault
);

  logic                commit_en;
  logic [2*DATA_W-1:0] rd_bus;

  priv_gate #(.NUM_REGS(NUM_REGS), .SYS_FIRST(SYS_FIRST)) u_gate (
    .rst       (rst),
    .req_en    (wr_en),
    .req_idx   (wr_idx),
    .req_priv  (wr_priv),
    .commit_en (commit_en),
    .fault     (gp_fault)
  );

  reg_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_RD(2)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (commit_en),
    .widx  (wr_idx),
    .wdata (wr_data),
    .raddr ({rd_b_idx, rd_a_idx}),
    .rdata (rd_bus)
  );

  assign rd_a_data = rd_bus[DATA_W-1:0];
  assign rd_b_data = rd_bus[2*DATA_W-1:DATA_W];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0)); // R1

  AST_ZERO_SLOT: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == '0) |-> (rd_b_data == '0)); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0 && !gp_fault)
    |=> ((rd_a_idx == $past(wr_idx)) -> (rd_a_data == $past(wr_data)))); // R3

  AST_FAULT_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
    (gp_fault && rd_a_idx == wr_idx && !$past(rst))
    |=> ($stable(rd_a_idx) -> $stable(rd_a_data))); // R5

  AST_FAULT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    gp_fault |-> (wr_en && !wr_priv && wr_idx != '0)); // R6

endmodule

// File: tb/priv_regfile_test.sv
module priv_regfile_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_priv;
  logic [3:0]  wr_idx, rd_a_idx, rd_b_idx;
  logic [31:0] wr_data, rd_a_data, rd_b_data;
  logic        gp_fault;

  logic [31:0] model [16];
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  priv_regfile uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_priv(wr_priv), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .gp_fault(gp_fault)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive after falling edge, compare, then update model at rising edge
  task automatic cyc(input logic en, input logic [3:0] wi, input logic [31:0] wd,
                     input logic pv, input logic [3:0] ra, input logic [3:0] rb,
                     input string tag);
    logic exp_fault;
    wr_en = en; wr_idx = wi; wr_data = wd; wr_priv = pv;
    rd_a_idx = ra; rd_b_idx = rb;
    #1;
    exp_fault = en && !rst && !pv && (wi >= 4'd13);
    chk(tag, "port A", rd_a_data, model[ra]);
    chk(tag, "port B", rd_b_data, model[rb]);
    chk("R6", "gp_fault", {31'b0, gp_fault}, {31'b0, exp_fault});
    @(posedge clk);
    if (rst)
      foreach (model[i]) model[i] = '0;
    else if (en && wi != 0 && !(wi >= 4'd13 && !pv))
      model[wi] = wd;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(1'b0, 4'd0, '0, 1'b0, 4'd0, 4'd0, "R1");
    cyc(1'b0, 4'd0, '0, 1'b0, 4'd0, 4'd0, "R1");
    rst = 1'b0;
  endtask

  initial begin
    foreach (model[i]) model[i] = '0;
    rst = 1'b1; wr_en = 0; wr_idx = 0; wr_data = 0; wr_priv = 0;
    rd_a_idx = 0; rd_b_idx = 0;
    @(negedge clk);
    do_reset();
    // R1: every index reads zero after reset
    for (int i = 0; i < 16; i += 2)
      cyc(1'b0, 4'd0, '0, 1'b0, 4'(i), 4'(i + 1), "R1");
    // R2: zero slot ignores writes, no fault
    cyc(1'b1, 4'd0, 32'hDEAD_BEEF, 1'b1, 4'd0, 4'd0, "R2");
    cyc(1'b1, 4'd0, 32'h1234_5678, 1'b0, 4'd0, 4'd0, "R2");
    cyc(1'b0, 4'd0, '0, 1'b0, 4'd0, 4'd0, "R2");
    // R3 and R7: same-cycle read sees old value, next cycle sees new
    cyc(1'b1, 4'd5, 32'hAAAA_5555, 1'b0, 4'd5, 4'd5, "R7");
    cyc(1'b1, 4'd5, 32'h0F0F_F0F0, 1'b1, 4'd5, 4'd1, "R7");
    cyc(1'b0, 4'd0, '0, 1'b0, 4'd5, 4'd5, "R3");
    cyc(1'b1, 4'd12, 32'h8000_0000, 1'b0, 4'd12, 4'd1, "R9");
    cyc(1'b0, 4'd0, '0, 1'b0, 4'd12, 4'd12, "R3");
    // R5: unprivileged system writes blocked
    cyc(1'b1, 4'd13, 32'hCAFE_0001, 1'b0, 4'd13, 4'd14, "R5");
    cyc(1'b1, 4'd15, 32'hCAFE_0003, 1'b0, 4'd13, 4'd15, "R5");
    // R4: privileged system writes land
    cyc(1'b1, 4'd14, 32'h1357_9BDF, 1'b1, 4'd14, 4'd13, "R4");
    cyc(1'b1, 4'd15, 32'hFFFF_FFFF, 1'b1, 4'd14, 4'd15, "R4");
    // R8/R9: read system entries with no privilege, full patterns
    cyc(1'b0, 4'd0, '0, 1'b0, 4'd15, 4'd14, "R8");
    cyc(1'b1, 4'd14, 32'h0, 1'b0, 4'd14, 4'd15, "R5");
    cyc(1'b0, 4'd0, '0, 1'b0, 4'd14, 4'd15, "R9");
    // mixed traffic, both ports, both privilege levels
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] wi, ra, rb;
      wi = 4'($urandom_range(0, 15));
      ra = 4'($urandom_range(0, 15));
      rb = (n % 5 == 0) ? wi : 4'($urandom_range(0, 15));
      cyc(1'($urandom_range(0, 1)), wi, $urandom(), 1'($urandom_range(0, 1)),
          ra, rb, "R8");
    end
    // R1 again mid-run
    do_reset();
    for (int i = 0; i < 16; i += 2)
      cyc(1'b0, 4'd0, '0, 1'b0, 4'(i), 4'(i + 1), "R1");
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule